// File: doc/BRIEF.md
# Multi-Level Prioritized Vectored Interrupt Controller

This block gathers 82 level-sensitive interrupt request lines. It picks the single request that the processor core should take next and hands the core three things: a request flag, a vector address and a compressed level code. Software gives every source one of four priority levels and a separate enable bit. A small group of sources has a level fixed in hardware. All of these settings, and a vector base value, sit in 16-bit registers on a simple single-cycle register bus.

Arbitration runs in two steps. It first finds the highest priority level that has an enabled, active request and that the core's 2-bit mask allows. A mask value of m admits only levels m and above, so level 3 is the most urgent. Within that level, the lowest-numbered source wins. The vector address is the base register followed by the 7-bit source number. The outputs are registered, so they follow a change at the inputs, the mask or the registers one clock later.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every writable priority field, every enable bit and the base register read as zero. The hard-wired sources 0 and 1 read as level 3. irq_req and irq_lvl are low.
- R2: Register map. Address a in 0..10 holds the levels of sources 8a..8a+7, with source 8a+k in bits 2k+1:2k. Address 11+b holds the enables of sources 16b..16b+15, with source 16b+k in bit k. Address 17 holds the 9-bit vector base in bits 8:0. Unused bits and unused addresses read as zero. A write takes effect at the next clock and reads back.
- R3: A source whose enable bit is 0 is never selected, whatever its request line does.
- R4: With core_mask = m, only sources at level m or above can be selected. With m = 3, only level 3 can be selected.
- R5: Among enabled, unmasked, active sources, the winner always has the highest level present.
- R6: Within the winning level, the lowest-numbered active source wins.
- R7: irq_vec = {base[8:0], winner[6:0]}.
- R8: irq_lvl reports the winner's level. It is 01 for level 0, 10 for level 1, and 11 for level 2 or 3.
- R9: Writes to the level fields of sources 0 and 1 are ignored. Those sources stay at level 3.
- R10: When no source qualifies, irq_req is 0 and irq_lvl is 00.
- R11: irq_req, irq_vec and irq_lvl change on the first clock edge after a change at the request, mask or register inputs, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_src | input | 82 | Level-sensitive request lines, bit n is source n |
| core_mask | input | 2 | Core interrupt mask bits (status register bits 9:8) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Vector address: base followed by the source number |
| irq_lvl | output | 2 | Encoded level of the pending request |

## Verification
The assertions assume that irq_src, core_mask and the bus inputs change only away from the rising edge, and that they hold steady across it. The bench therefore drives every input on the falling edge and samples on the next falling edge. The assertions also assume that a register write lasts exactly one cycle. The bus task guarantees this by raising reg_wr for a single clock period. The window checks that compare the outputs with the previous cycle's arbitration rely on that previous cycle being out of reset. The stimulus gives reset several clocks before any request or write arrives.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef logic [1:0] lvl_t;

  // a level may be taken when it is at or above the core mask value
  function automatic logic lvl_allowed(lvl_t mask, lvl_t lvl);
    return lvl >= mask;
  endfunction

  // compressed level code reported to the core
  function automatic lvl_t lvl_code(logic valid, lvl_t lvl);
    if (!valid)            return 2'b00;
    else if (lvl == 2'd0)  return 2'b01;
    else if (lvl == 2'd1)  return 2'b10;
    else                   return 2'b11;
  endfunction
endpackage

// File: rtl/pic_regfile.sv
module pic_regfile #(
  parameter int N_SRC     = 82,
  parameter int DW        = 16,
  parameter int ADDR_W    = 5,
  parameter int BASE_W    = 9,
  parameter int FIXED_CNT = 2,
  parameter logic [1:0] FIXED_LVL = 2'd3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DW-1:0]       reg_wdata,
  output logic [DW-1:0]       reg_rdata,
  output logic [2*N_SRC-1:0]  lvl_flat,
  output logic [N_SRC-1:0]    en_vec,
  output logic [BASE_W-1:0]   base_q
);
  localparam int PER_PRIO  = DW / 2;
  localparam int PRIO_REGS = (N_SRC + PER_PRIO - 1) / PER_PRIO;
  localparam int EN_REGS   = (N_SRC + DW - 1) / DW;
  localparam int EN_BASE   = PRIO_REGS;
  localparam int BASE_ADDR = PRIO_REGS + EN_REGS;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    localparam int PR = s / PER_PRIO;
    localparam int PB = 2 * (s % PER_PRIO);
    localparam int ER = EN_BASE + s / DW;
    localparam int EB = s % DW;
    if (s < FIXED_CNT) begin : g_fix
      assign lvl_flat[2*s +: 2] = FIXED_LVL;
    end else begin : g_prog
      logic [1:0] lvl_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) lvl_q <= '0;
        else if (reg_wr && reg_addr == ADDR_W'(PR)) lvl_q <= reg_wdata[PB +: 2];
      assign lvl_flat[2*s +: 2] = lvl_q;
    end
    logic en_q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) en_q <= 1'b0;
      else if (reg_wr && reg_addr == ADDR_W'(ER)) en_q <= reg_wdata[EB];
    assign en_vec[s] = en_q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) base_q <= '0;
    else if (reg_wr && reg_addr == ADDR_W'(BASE_ADDR)) base_q <= reg_wdata[BASE_W-1:0];

  logic [PRIO_REGS*DW-1:0] lvl_pad;
  logic [EN_REGS*DW-1:0]   en_pad;
  always_comb begin
    lvl_pad = '0;
    lvl_pad[2*N_SRC-1:0] = lvl_flat;
    en_pad = '0;
    en_pad[N_SRC-1:0] = en_vec;
  end

  always_comb begin
    int a;
    a = int'(reg_addr);
    reg_rdata = '0;
    if (a < PRIO_REGS)                 reg_rdata = lvl_pad[a*DW +: DW];
    else if (a < BASE_ADDR)            reg_rdata = en_pad[(a-EN_BASE)*DW +: DW];
    else if (a == BASE_ADDR)           reg_rdata[BASE_W-1:0] = base_q;
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
#(
  parameter int N_SRC = 82,
  parameter int VEC_W = 7
) (
  input  logic [N_SRC-1:0]   req_in,
  input  logic [N_SRC-1:0]   en_vec,
  input  logic [2*N_SRC-1:0] lvl_flat,
  input  lvl_t               mask,
  output logic               win_valid,
  output logic [VEC_W-1:0]   win_idx,
  output lvl_t               win_lvl,
  output logic [3:0]         lvl_hit
);
  logic [N_SRC-1:0] cand;
  assign cand = req_in & en_vec;

  // levels that have at least one qualifying request
  always_comb begin
    lvl_hit = '0;
    for (int s = 0; s < N_SRC; s++)
      if (cand[s]) lvl_hit[lvl_flat[2*s +: 2]] = 1'b1;
  end

  // highest admitted level wins (ascending scan, last hit kept)
  always_comb begin
    win_valid = 1'b0;
    win_lvl   = '0;
    for (int l = 0; l < 4; l++)
      if (lvl_hit[l] && lvl_allowed(mask, lvl_t'(l))) begin
        win_valid = 1'b1;
        win_lvl   = lvl_t'(l);
      end
  end

  // lowest index inside the winning level (descending scan, last hit kept)
  always_comb begin
    win_idx = '0;
    for (int s = N_SRC - 1; s >= 0; s--)
      if (cand[s] && lvl_flat[2*s +: 2] == win_lvl) win_idx = VEC_W'(s);
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int N_SRC     = 82,
  parameter int DW        = 16,
  parameter int ADDR_W    = 5,
  parameter int BASE_W    = 9,
  parameter int VEC_W     = 7,
  parameter int FIXED_CNT = 2,
  parameter logic [1:0] FIXED_LVL = 2'd3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        irq_src,
  input  logic [1:0]              core_mask,
  input  logic                    reg_wr,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [DW-1:0]           reg_wdata,
  output logic [DW-1:0]           reg_rdata,
  output logic                    irq_req,
  output logic [BASE_W+VEC_W-1:0] irq_vec,
  output logic [1:0]              irq_lvl
);
  localparam int PRIO_REGS = (N_SRC + DW/2 - 1) / (DW/2);
  localparam int EN_REGS   = (N_SRC + DW - 1) / DW;
  localparam int BASE_ADDR = PRIO_REGS + EN_REGS;

  logic [2*N_SRC-1:0] lvl_flat;
  logic [N_SRC-1:0]   en_vec;
  logic [BASE_W-1:0]  base_q;
  logic               arb_valid;
  logic [VEC_W-1:0]   arb_idx;
  lvl_t               arb_lvl;
  logic [3:0]         arb_hit;

  pic_regfile #(
    .N_SRC(N_SRC), .DW(DW), .ADDR_W(ADDR_W), .BASE_W(BASE_W),
    .FIXED_CNT(FIXED_CNT), .FIXED_LVL(FIXED_LVL)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lvl_flat(lvl_flat), .en_vec(en_vec), .base_q(base_q)
  );

  pic_arbiter #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_arb (
    .req_in(irq_src), .en_vec(en_vec), .lvl_flat(lvl_flat), .mask(core_mask),
    .win_valid(arb_valid), .win_idx(arb_idx), .win_lvl(arb_lvl), .lvl_hit(arb_hit)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
      irq_lvl <= 2'b00;
    end else begin
      irq_req <= arb_valid;
      irq_vec <= {base_q, arb_idx};
      irq_lvl <= lvl_code(arb_valid, arb_lvl);
    end

  assert_base_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(BASE_ADDR)) |=> base_q == $past(reg_wdata[BASE_W-1:0]));
  assert_en_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arb_valid |-> (en_vec[arb_idx] && irq_src[arb_idx]));
  assert_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arb_valid |-> arb_lvl >= core_mask);
  assert_top_lvl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arb_valid |-> ((arb_hit >> (int'(arb_lvl) + 1)) == 4'd0));
  assert_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arb_valid |=> (irq_req && irq_vec == {$past(base_q), $past(arb_idx)}));
  assert_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_lvl != 2'b00);
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> irq_lvl == 2'b00);
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int N = 82;
  localparam int BASE_ADDR = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq_src = '0;
  logic [1:0]  core_mask = 2'b00;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_req;
  logic [15:0] irq_vec;
  logic [1:0]  irq_lvl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [1:0] lvl_m [N];
  bit         en_m  [N];
  logic [8:0] base_m;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .core_mask(core_mask),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl)
  );

  function automatic logic [31:0] next_rand(logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  task automatic rnd(output logic [31:0] r);
    lfsr = next_rand(lfsr);
    lfsr = next_rand(lfsr);
    r = lfsr * 32'd2654435761;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(int a);
    logic [15:0] d;
    d = '0;
    if (a < 11) begin
      for (int k = 0; k < 8; k++)
        if (a*8 + k < N) d[2*k +: 2] = lvl_m[a*8 + k];
    end else if (a < 17) begin
      for (int k = 0; k < 16; k++)
        if ((a-11)*16 + k < N) d[k] = en_m[(a-11)*16 + k];
    end else if (a == BASE_ADDR) d[8:0] = base_m;
    return d;
  endfunction

  task automatic bus_write(int a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a < 11) begin
      for (int k = 0; k < 8; k++)
        if (a*8 + k < N && a*8 + k >= 2) lvl_m[a*8 + k] = d[2*k +: 2];
    end else if (a < 17) begin
      for (int k = 0; k < 16; k++)
        if ((a-11)*16 + k < N) en_m[(a-11)*16 + k] = d[k];
    end else if (a == BASE_ADDR) base_m = d[8:0];
  endtask

  task automatic read_check(int a, string tag);
    reg_addr = 5'(a);
    #1;
    chk(tag, 32'(reg_rdata), 32'(exp_read(a)));
  endtask

  // expected outputs restated: scan from the most urgent level downward
  task automatic check_out(string tag);
    int win;
    int wl;
    win = -1; wl = 0;
    for (int l = 3; l >= int'(core_mask) && win < 0; l--)
      for (int s = 0; s < N && win < 0; s++)
        if (irq_src[s] && en_m[s] && int'(lvl_m[s]) == l) begin win = s; wl = l; end
    if (win < 0) begin
      chk({tag, " R10 req"}, 32'(irq_req), 0);
      chk({tag, " R10 lvl"}, 32'(irq_lvl), 0);
    end else begin
      chk({tag, " R5 R6 req"}, 32'(irq_req), 1);
      chk({tag, " R7 vec"}, 32'(irq_vec), (32'(base_m) << 7) + 32'(win));
      chk({tag, " R8 lvl"}, 32'(irq_lvl), (wl >= 2) ? 3 : wl + 1);
    end
  endtask

  task automatic apply(logic [N-1:0] src, logic [1:0] m, string tag);
    @(negedge clk);
    irq_src = src; core_mask = m;
    @(negedge clk);
    check_out(tag);
  endtask

  initial begin
    for (int s = 0; s < N; s++) begin lvl_m[s] = (s < 2) ? 2'd3 : 2'd0; en_m[s] = 0; end
    base_m = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req", 32'(irq_req), 0);
    chk("R1 lvl", 32'(irq_lvl), 0);
    for (int a = 0; a < 20; a++) read_check(a, "R1 reset read");

    // R2 readback of base and map
    bus_write(BASE_ADDR, 16'hFF5A);
    read_check(BASE_ADDR, "R2 base");
    bus_write(3, 16'hE41B);
    read_check(3, "R2 prio reg");
    bus_write(12, 16'h8001);
    read_check(12, "R2 enable reg");
    read_check(25, "R2 unmapped");

    // R9 fixed sources ignore writes
    bus_write(0, 16'h0000);
    read_check(0, "R9 fixed read");

    // R3 all requests, nothing enabled
    for (int a = 11; a < 17; a++) bus_write(a, 16'h0000);
    apply('1, 2'b00, "R3 disabled");

    // single-source sweep: each source at level s%4, every mask
    for (int s = 0; s < N; s++) begin
      logic [15:0] pv;
      pv = exp_read(s/8);
      pv[2*(s%8) +: 2] = 2'(s % 4);
      bus_write(s/8, pv);
      bus_write(11 + s/16, 16'(1 << (s % 16)));
      for (int m = 0; m < 4; m++) apply(N'(1) << s, 2'(m), "R4 sweep");
      bus_write(11 + s/16, 16'h0000);
    end

    // R11 latency: output holds until the edge
    bus_write(11, 16'h0004);
    apply('0, 2'b00, "R11 idle");
    @(negedge clk);
    irq_src = N'(4);
    #1;
    chk("R11 before edge", 32'(irq_req), 0);
    @(negedge clk);
    check_out("R11 after edge");

    // random patterns, reprogramming from time to time
    for (int it = 0; it < 300; it++) begin
      logic [31:0] r0, r1, r2, r3, r4, r5;
      logic [N-1:0] src;
      if (it % 8 == 0) begin
        rnd(r0); bus_write(int'(r0 % 11), r0[31:16]);
        rnd(r1); bus_write(11 + int'(r1 % 6), r1[15:0] | r1[31:16]);
        rnd(r1); if (r1[3]) bus_write(BASE_ADDR, r1[15:0]);
      end
      rnd(r2); rnd(r3); rnd(r4); rnd(r5);
      src = {r2, r3, r4} & N'({r5, r4, r2} | {r3, r5, r4});
      if (it % 3 == 0) src = src & {r5, r2, r3};
      for (int m = 0; m < 4; m++) apply(src, 2'(m), "R5 R6 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule